// File: doc/BRIEF.md
# Serial Controller Control Word Sequencer

This block is the processor-side register interface of a programmable serial controller. It watches an 8-bit bus, a control/data select line and active-low chip select, read and write strobes. Each strobe counts once, on the clock edge where it is first seen active. A control write (select high) means something different depending on how far the block has got since reset. The first one is the mode word. In synchronous mode, one or two sync characters follow it. After that, every control write is a command word.

The block holds the mode, sync and command registers and exports their fields as configuration and enable levels. It keeps sticky parity, overrun and framing error flags, and returns a status byte on control reads. Data writes and data reads pass straight through. A data write gives a one-cycle strobe with the byte. A data read returns the received byte from outside and gives a one-cycle read strobe. Serial shifting is not done here.

The sequencer has four states. WAIT_MODE is entered on reset. WAIT_SYNC1 and WAIT_SYNC2 collect sync characters. RUN takes commands. The transitions are:
- WAIT_MODE to RUN on an asynchronous mode word.
- WAIT_MODE to WAIT_SYNC1 on a synchronous mode word.
- WAIT_SYNC1 to RUN when a single sync character was selected.
- WAIT_SYNC1 to WAIT_SYNC2 when two sync characters were selected.
- WAIT_SYNC2 to RUN on the second sync character.
- RUN back to WAIT_MODE on a command with the internal-reset bit set.

Top module: `usart_ctrl_seq`

## Requirements
- R1: While `rst` is high and after it is released, the sequencer is in WAIT_MODE: `configured_o` is 0, all command outputs are 0 and the three error flags read 0.
- R2: A strobe with `cs_n` high has no effect: no register, flag or state changes and no strobe output pulses.
- R3: The first control write after reset is stored as the mode word. If bits [1:0] are not 00, the block enters RUN, so `configured_o` becomes 1.
- R4: A mode word with bits [1:0] = 00 selects synchronous mode, and `sync_mode_o` becomes 1. Mode bit 7 = 1 means one sync character and bit 7 = 0 means two. The sync characters are taken in order into `sync1_o` and `sync2_o`, and `configured_o` rises only after the last one.
- R5: In RUN, a control write loads the command register. Bit 0 drives `tx_en_o`, bit 1 `dtr_o`, bit 2 `rx_en_o`, bit 3 `break_o`, bit 5 `rts_o` and bit 7 `hunt_o`.
- R6: A command with bit 6 set is an internal reset. It clears all command outputs and the error flags and returns the sequencer to WAIT_MODE, so the next control write is a mode word.
- R7: A one-cycle pulse on `pe_i`, `oe_i` or `fe_i` sets the matching sticky flag. A command with bit 4 set clears all three flags, and bit 4 is not kept as an output.
- R8: A control read (cs_n=0, rd_n=0, cd=1) drives `dout` with the status byte. From bit 0 to bit 7 it holds: tx ready, rx ready, tx empty, parity error, overrun error, framing error, sync detect, data set ready. At all other times `dout` is 0.
- R9: A data read drives `dout` with `rx_data_i` and pulses `data_rd_o` for exactly one cycle. A data write pulses `data_wr_o` for exactly one cycle, with the written byte on `wr_data_o`.
- R10: The mode fields are exported as follows: bits [1:0] to `baud_sel_o` (01 = x1, 10 = x16, 11 = x64), [3:2] to `char_len_o`, bit 4 to `parity_en_o`, bit 5 to `parity_even_o`, [7:6] to `stop_sel_o`, bit 6 to `ext_sync_o` and bit 7 to `single_sync_o`.
- R11: Data writes never advance the sequence or change the mode, sync or command registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous external reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 = control/status, 0 = data |
| din | input | 8 | Write bus |
| dout | output | 8 | Read bus |
| rx_data_i | input | 8 | Received byte from the receiver |
| tx_rdy_i | input | 1 | Transmitter ready status |
| rx_rdy_i | input | 1 | Receiver ready status |
| tx_empty_i | input | 1 | Transmitter empty status |
| syndet_i | input | 1 | Sync detect status |
| dsr_i | input | 1 | Data set ready status |
| pe_i | input | 1 | Parity error event pulse |
| oe_i | input | 1 | Overrun error event pulse |
| fe_i | input | 1 | Framing error event pulse |
| configured_o | output | 1 | Sequencer in RUN |
| sync_mode_o | output | 1 | Synchronous mode selected |
| baud_sel_o | output | 2 | Mode bits [1:0] |
| char_len_o | output | 2 | Character length code |
| parity_en_o | output | 1 | Parity enable |
| parity_even_o | output | 1 | Even parity |
| stop_sel_o | output | 2 | Stop length code |
| ext_sync_o | output | 1 | External sync select |
| single_sync_o | output | 1 | One sync character |
| sync1_o | output | 8 | First sync character |
| sync2_o | output | 8 | Second sync character |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| dtr_o | output | 1 | Terminal ready output level |
| rts_o | output | 1 | Request-to-send output level |
| break_o | output | 1 | Send break |
| hunt_o | output | 1 | Enter hunt |
| data_wr_o | output | 1 | Data write strobe |
| wr_data_o | output | 8 | Data write byte |
| data_rd_o | output | 1 | Data read strobe |

## Verification
If the sequencer is in the wrong state, a control write is filed in the wrong register. That shows at the ports on the very next cycle: a command appears as mode fields, a sync character lands in the command outputs, or `configured_o` rises too early or too late. The bench therefore walks all three sequence lengths, an internal reset from RUN, and data writes in between. After every control write it compares the exported fields. A flag that fails to set or clear shows on the next status read. Strobe counts are checked against a queue of the data bytes written.

// File: rtl/usart_seq_pkg.sv
package usart_seq_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        WAIT_MODE  = 2'd0,
        WAIT_SYNC1 = 2'd1,
        WAIT_SYNC2 = 2'd2,
        RUN        = 2'd3
    } seq_state_t;

    localparam int CMD_TXEN  = 0;
    localparam int CMD_DTR   = 1;
    localparam int CMD_RXEN  = 2;
    localparam int CMD_BRK   = 3;
    localparam int CMD_ERCLR = 4;
    localparam int CMD_RTS   = 5;
    localparam int CMD_IRST  = 6;
    localparam int CMD_HUNT  = 7;

    localparam int MODE_SINGLE = 7;
endpackage

// File: rtl/usart_bus_if.sv
module usart_bus_if #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cd,
    input  logic [DW-1:0] din,
    output logic          ctrl_wr,
    output logic          data_wr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          data_rd_o
);
    logic wr_act, rd_act, wr_act_q, rd_act_q, wr_ev, rd_ev;

    assign wr_act  = ~cs_n & ~wr_n;
    assign rd_act  = ~cs_n & ~rd_n;
    assign wr_ev   = wr_act & ~wr_act_q;
    assign rd_ev   = rd_act & ~rd_act_q;
    assign ctrl_wr = wr_ev & cd;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q  <= 1'b0;
            rd_act_q  <= 1'b0;
            data_wr_o <= 1'b0;
            data_rd_o <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_act_q  <= wr_act;
            rd_act_q  <= rd_act;
            data_wr_o <= wr_ev & ~cd;
            data_rd_o <= rd_ev & ~cd;
            if (wr_ev && !cd) wr_data_o <= din;
        end
    end

    AST_DWR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        data_wr_o |=> !data_wr_o); // R9
    AST_DRD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        data_rd_o |=> !data_rd_o); // R9
endmodule

// File: rtl/usart_seq_fsm.sv
module usart_seq_fsm
    import usart_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] din,
    output seq_state_t    state_q,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] sync1_q,
    output logic [DW-1:0] sync2_q,
    output logic [DW-1:0] cmd_q,
    output logic          err_clr
);
    seq_state_t state_d;
    logic       mode_is_sync;

    assign mode_is_sync = (din[1:0] == 2'b00);
    assign err_clr = ctrl_wr && (state_q == RUN) && (din[CMD_ERCLR] || din[CMD_IRST]);

    always_ff @(posedge clk) begin
        if (rst) state_q <= WAIT_MODE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_MODE:  if (ctrl_wr) state_d = mode_is_sync ? WAIT_SYNC1 : RUN;
            WAIT_SYNC1: if (ctrl_wr) state_d = mode_q[MODE_SINGLE] ? RUN : WAIT_SYNC2;
            WAIT_SYNC2: if (ctrl_wr) state_d = RUN;
            RUN:        if (ctrl_wr && din[CMD_IRST]) state_d = WAIT_MODE;
            default:    state_d = WAIT_MODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
            cmd_q   <= '0;
        end else if (ctrl_wr) begin
            unique case (state_q)
                WAIT_MODE:  mode_q  <= din;
                WAIT_SYNC1: sync1_q <= din;
                WAIT_SYNC2: sync2_q <= din;
                RUN: begin
                    if (din[CMD_IRST]) cmd_q <= '0;
                    else begin
                        cmd_q <= din;
                        cmd_q[CMD_ERCLR] <= 1'b0;
                        cmd_q[CMD_IRST]  <= 1'b0;
                    end
                end
                default: cmd_q <= '0;
            endcase
        end
    end

    AST_IDLE_CMD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == WAIT_MODE) |-> (cmd_q == '0)); // R1
    AST_ASYNC_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == WAIT_MODE && ctrl_wr && din[1:0] != 2'b00) |=> (state_q == RUN)); // R3
    AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == WAIT_SYNC1 && ctrl_wr) |=> (state_q == WAIT_SYNC2 || state_q == RUN)); // R4
    AST_IRST_BACK: assert property (@(posedge clk) disable iff (rst)
        (state_q == RUN && ctrl_wr && din[CMD_IRST]) |=> (state_q == WAIT_MODE && cmd_q == '0)); // R6
    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> ($stable(state_q) && $stable(mode_q) && $stable(cmd_q))); // R11
endmodule

// File: rtl/usart_err_flags.sv
module usart_err_flags (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic pe_i,
    input  logic oe_i,
    input  logic fe_i,
    output logic pe_q,
    output logic oe_q,
    output logic fe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pe_q <= 1'b0;
            oe_q <= 1'b0;
            fe_q <= 1'b0;
        end else begin
            pe_q <= (pe_q & ~clr) | pe_i;
            oe_q <= (oe_q & ~clr) | oe_i;
            fe_q <= (fe_q & ~clr) | fe_i;
        end
    end

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr && !pe_i && !oe_i && !fe_i) |=> (!pe_q && !oe_q && !fe_q)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pe_q && !clr) |=> pe_q); // R7
endmodule

// File: rtl/usart_ctrl_seq.sv
module usart_ctrl_seq
    import usart_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       cd,
    input  logic [7:0] din,
    output logic [7:0] dout,
    input  logic [7:0] rx_data_i,
    input  logic       tx_rdy_i,
    input  logic       rx_rdy_i,
    input  logic       tx_empty_i,
    input  logic       syndet_i,
    input  logic       dsr_i,
    input  logic       pe_i,
    input  logic       oe_i,
    input  logic       fe_i,
    output logic       configured_o,
    output logic       sync_mode_o,
    output logic [1:0] baud_sel_o,
    output logic [1:0] char_len_o,
    output logic       parity_en_o,
    output logic       parity_even_o,
    output logic [1:0] stop_sel_o,
    output logic       ext_sync_o,
    output logic       single_sync_o,
    output logic [7:0] sync1_o,
    output logic [7:0] sync2_o,
    output logic       tx_en_o,
    output logic       rx_en_o,
    output logic       dtr_o,
    output logic       rts_o,
    output logic       break_o,
    output logic       hunt_o,
    output logic       data_wr_o,
    output logic [7:0] wr_data_o,
    output logic       data_rd_o
);
    seq_state_t state_q;
    logic [DW-1:0] mode_q, cmd_q, status;
    logic ctrl_wr, err_clr, pe_q, oe_q, fe_q;

    usart_bus_if #(.DW(DW)) u_bus (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
        .din(din), .ctrl_wr(ctrl_wr), .data_wr_o(data_wr_o),
        .wr_data_o(wr_data_o), .data_rd_o(data_rd_o)
    );

    usart_seq_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .din(din), .state_q(state_q),
        .mode_q(mode_q), .sync1_q(sync1_o), .sync2_q(sync2_o), .cmd_q(cmd_q),
        .err_clr(err_clr)
    );

    usart_err_flags u_err (
        .clk(clk), .rst(rst), .clr(err_clr), .pe_i(pe_i), .oe_i(oe_i),
        .fe_i(fe_i), .pe_q(pe_q), .oe_q(oe_q), .fe_q(fe_q)
    );

    assign status = {dsr_i, syndet_i, fe_q, oe_q, pe_q, tx_empty_i, rx_rdy_i, tx_rdy_i};

    always_comb begin
        dout = '0;
        if (!cs_n && !rd_n) dout = cd ? status : rx_data_i;
    end

    assign configured_o  = (state_q == RUN);
    assign baud_sel_o    = mode_q[1:0];
    assign sync_mode_o   = (mode_q[1:0] == 2'b00);
    assign char_len_o    = mode_q[3:2];
    assign parity_en_o   = mode_q[4];
    assign parity_even_o = mode_q[5];
    assign stop_sel_o    = mode_q[7:6];
    assign ext_sync_o    = mode_q[6];
    assign single_sync_o = mode_q[MODE_SINGLE];
    assign tx_en_o       = cmd_q[CMD_TXEN];
    assign dtr_o         = cmd_q[CMD_DTR];
    assign rx_en_o       = cmd_q[CMD_RXEN];
    assign break_o       = cmd_q[CMD_BRK];
    assign rts_o         = cmd_q[CMD_RTS];
    assign hunt_o        = cmd_q[CMD_HUNT];

    AST_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(configured_o) && $stable(cmd_q) && $stable(mode_q))); // R2
    AST_NO_SELECT_STROBE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> (!data_wr_o && !data_rd_o)); // R2
endmodule

// File: tb/usart_ctrl_seq_bench.sv
module usart_ctrl_seq_bench;
    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic [7:0] din = '0, rx_data_i = '0, dout;
    logic tx_rdy_i = 0, rx_rdy_i = 0, tx_empty_i = 0, syndet_i = 0, dsr_i = 0;
    logic pe_i = 0, oe_i = 0, fe_i = 0;
    logic configured_o, sync_mode_o, parity_en_o, parity_even_o, ext_sync_o, single_sync_o;
    logic [1:0] baud_sel_o, char_len_o, stop_sel_o;
    logic [7:0] sync1_o, sync2_o, wr_data_o;
    logic tx_en_o, rx_en_o, dtr_o, rts_o, break_o, hunt_o, data_wr_o, data_rd_o;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rd_val;
    logic rd_pulse;

    always #2 clk = ~clk;

    usart_ctrl_seq u_usart_ctrl_seq (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic c, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs_n = ~sel; cd = c; din = d; wr_n = 1'b0;
        if (sel && !c) exp_q.push_back(d);
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic cpu_rd(input logic c);
        @(negedge clk);
        cs_n = 1'b0; cd = c; rd_n = 1'b0;
        #1 rd_val = dout;
        @(negedge clk);
        rd_pulse = data_rd_o;
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    function automatic logic [7:0] cmd_vec();
        return {hunt_o, 1'b0, rts_o, 1'b0, break_o, rx_en_o, dtr_o, tx_en_o};
    endfunction

    // scoreboard monitor for data write strobes
    always @(negedge clk) begin
        if (!rst && data_wr_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected data strobe actual %0h expected none", wr_data_o);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (wr_data_o !== e) begin
                    errors++;
                    $display("FAIL R9 data byte actual %0h expected %0h", wr_data_o, e);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (8) @(negedge clk);
        chk("R1 configured in reset", configured_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 configured after reset", configured_o, 0);
        chk("R1 command outputs", cmd_vec(), 0);
        cpu_rd(1'b1);
        chk("R1 error flags", rd_val[5:3], 0);

        // R2: deselected control write ignored
        cpu_wr(1'b1, 8'h7E, 1'b0);
        chk("R2 deselected write", {configured_o, baud_sel_o}, 0);

        // R3 / R10: async mode word
        cpu_wr(1'b1, 8'h7E);
        chk("R3 configured", configured_o, 1);
        chk("R10 baud", baud_sel_o, 2'd2);
        chk("R10 char len", char_len_o, 2'd3);
        chk("R10 parity", {parity_en_o, parity_even_o}, 2'b11);
        chk("R10 stop", stop_sel_o, 2'd1);
        chk("R3 not sync", sync_mode_o, 0);

        // R5 commands
        cpu_wr(1'b1, 8'h27);
        chk("R5 cmd 27", cmd_vec(), 8'h27);
        cpu_wr(1'b0, 8'h5A);
        chk("R11 data write keeps cmd", cmd_vec(), 8'h27);
        chk("R11 data write keeps mode", baud_sel_o, 2'd2);
        cpu_wr(1'b1, 8'h88);
        chk("R5 cmd 88", cmd_vec(), 8'h88);

        // R7 error flags
        @(negedge clk); pe_i = 1; fe_i = 1;
        @(negedge clk); pe_i = 0; fe_i = 0;
        cpu_rd(1'b1);
        chk("R7 flags set", rd_val[5:3], 3'b101);
        @(negedge clk); oe_i = 1;
        @(negedge clk); oe_i = 0;
        cpu_rd(1'b1);
        chk("R7 flags sticky", rd_val[5:3], 3'b111);
        cpu_wr(1'b1, 8'h10);
        chk("R7 clear bit not kept", cmd_vec(), 0);
        cpu_rd(1'b1);
        chk("R7 flags cleared", rd_val[5:3], 0);

        // R8 status layout
        tx_rdy_i = 1; rx_rdy_i = 0; tx_empty_i = 1; syndet_i = 1; dsr_i = 1;
        @(negedge clk); oe_i = 1;
        @(negedge clk); oe_i = 0;
        cpu_rd(1'b1);
        chk("R8 status byte", rd_val, 8'hD5);
        chk("R8 no status strobe", rd_pulse, 0);
        #1 chk("R8 idle bus", dout, 0);

        // R9 data read
        rx_data_i = 8'hC3;
        cpu_rd(1'b0);
        chk("R9 data read", rd_val, 8'hC3);
        chk("R9 read strobe", rd_pulse, 1);
        @(negedge clk);
        chk("R9 read strobe single", data_rd_o, 0);

        // R6 internal reset then sync mode with two chars
        cpu_wr(1'b1, 8'h25);
        cpu_wr(1'b1, 8'h40);
        chk("R6 back to mode wait", configured_o, 0);
        chk("R6 cmds cleared", cmd_vec(), 0);
        cpu_rd(1'b1);
        chk("R6 flags cleared", rd_val[5:3], 0);
        cpu_wr(1'b1, 8'h00);
        chk("R4 sync mode", {sync_mode_o, configured_o}, 2'b10);
        cpu_wr(1'b0, 8'hA5);
        cpu_wr(1'b1, 8'h16);
        chk("R4 after first sync", configured_o, 0);
        chk("R4 sync1", sync1_o, 8'h16);
        cpu_wr(1'b1, 8'h2A);
        chk("R4 after second sync", configured_o, 1);
        chk("R4 sync2", sync2_o, 8'h2A);
        cpu_wr(1'b1, 8'h01);
        chk("R5 tx enable", cmd_vec(), 8'h01);

        // R4 single sync char, external sync
        cpu_wr(1'b1, 8'h40);
        cpu_wr(1'b1, 8'hC0);
        chk("R10 ext single", {ext_sync_o, single_sync_o}, 2'b11);
        cpu_wr(1'b1, 8'h99);
        chk("R4 single char done", configured_o, 1);
        chk("R4 single sync1", sync1_o, 8'h99);
        chk("R4 sync2 untouched", sync2_o, 8'h2A);
        cpu_wr(1'b1, 8'h04);
        chk("R5 rx enable", cmd_vec(), 8'h04);

        repeat (3) @(negedge clk);
        chk("R9 all data strobes seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule